// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Read Mode

This block is a parameterized first-in first-out buffer on a single clock. Words are stored in an inferred register array. Read and write pointers wrap modulo the configured depth. The block reports a stored-word count and four status flags: full, empty, almost-full and almost-empty. All flags come from registers and move one cycle after the request that changes them.

A parameter selects how the read side behaves:

- **Normal mode:** an accepted read request loads the oldest word into an output register one cycle later.
- **Lookahead mode:** the oldest word is already on the output whenever the FIFO is not empty. A read request acknowledges that word and moves on to the next one.

Further build options control the following:

- Writes while full can be refused (overflow guard).
- Reads while empty can be refused (underflow guard).
- A combined read and write on a full FIFO can be accepted, so that it stays full.

Two clears exist. The synchronous clear empties the FIFO at a clock edge. The asynchronous clear empties it at once and also serves as the block's reset.

Top module: `sfifo_la`

## Requirements
- R1: The depth is at least 4 and at most 2 to the power of the count width. When depth equals that power of two, `used_words` reads 0 while `full` is high, because the count is reported modulo 2^USED_W.
- R2: In normal mode, an accepted read updates `rd_data` one cycle later with the oldest stored word. Words leave in the order they were written.
- R3: In lookahead mode, whenever `empty` is low, `rd_data` shows the oldest stored word without any read request. An accepted read shows the next word one cycle later.
- R4: With the overflow guard on, a write request while full and without a read is ignored. The count stays the same and the stored contents stay the same.
- R5: With the underflow guard on, a read request while empty is ignored. `empty` stays high, the count stays 0, and in normal mode `rd_data` is unchanged.
- R6: With both the full-time read+write option and the overflow guard on, a simultaneous read and write on a full FIFO is accepted and the FIFO stays full. With the option off, only the read is taken, so the count drops by one.
- R7: `full`, `empty` and `used_words` change in the cycle after the request that changes them. `full` and `empty` are never high together.
- R8: `almost_full` is high exactly when the stored count is at least AF_LEVEL. `almost_empty` is high exactly when the stored count is below AE_LEVEL.
- R9: A high `sclr` at a clock edge does the following:
  - zeroes both pointers and the count;
  - raises `empty` and `almost_empty`;
  - drops `full` and `almost_full`;
  - ignores any read or write requested in that cycle.
  In normal mode it leaves `rd_data` unchanged.
- R10: `aclr` clears the pointers, count and flags at once, without waiting for a clock. In normal mode the `rd_data` register keeps its previous value.
- R11: In lookahead mode, for one cycle after a synchronous clear, `rd_data` keeps the word it showed before the clear.
- R12: A simultaneous accepted read and write on a FIFO that is neither full nor empty leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| aclr | input | 1 | Asynchronous clear, active high, also the reset |
| sclr | input | 1 | Synchronous clear, active high |
| wr_req | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_req | input | 1 | Read request (normal mode) or acknowledge of the shown word (lookahead mode) |
| rd_data | output | DATA_W | Output word |
| full | output | 1 | FIFO holds DEPTH words |
| empty | output | 1 | FIFO holds no words |
| almost_full | output | 1 | Count at or above AF_LEVEL |
| almost_empty | output | 1 | Count below AE_LEVEL |
| used_words | output | USED_W | Stored word count modulo 2^USED_W |

## Verification
The bench builds two copies of the block with depth 8 and a 3-bit count, so the case where the count wraps to 0 at full (R1) is reached. Both copies use an almost-full level of 6 and an almost-empty level of 2; every threshold boundary is crossed many times during filling and draining. One copy runs in normal mode with the full-time read+write option off. The other runs in lookahead mode with that option on. Because both copies receive the same stimulus, a combined request on a full FIFO shows the two R6 outcomes side by side. A queue model checks data order, flags and count every cycle through random traffic, directed overflow and underflow attempts, and clears issued mid-stream.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic {
        RD_NORMAL    = 1'b0,
        RD_LOOKAHEAD = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
    parameter int DEPTH     = 8,
    parameter int USED_W    = 3,
    parameter bit GUARD_OVF = 1'b1,
    parameter bit GUARD_UNF = 1'b1,
    parameter bit FULL_RW   = 1'b0,
    parameter int AF_LEVEL  = 6,
    parameter int AE_LEVEL  = 2
) (
    input  logic              clk,
    input  logic              aclr,
    input  logic              sclr,
    input  logic              wr_req,
    input  logic              rd_req,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic [USED_W-1:0] wr_ptr,
    output logic [USED_W-1:0] rd_ptr,
    output logic [USED_W-1:0] used_words,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty
);
    localparam int CW = USED_W + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] AF_C    = CW'(AF_LEVEL);
    localparam logic [CW-1:0] AE_C    = CW'(AE_LEVEL);

    typedef struct packed {
        logic [USED_W-1:0] wp;
        logic [USED_W-1:0] rp;
        logic [CW-1:0]     cnt;
        logic              full;
        logic              empty;
        logic              af;
        logic              ae;
    } ctrl_st_t;

    localparam ctrl_st_t CLEARED = '{wp: '0, rp: '0, cnt: '0, full: 1'b0,
                                     empty: 1'b1, af: 1'b0, ae: 1'b1};

    ctrl_st_t st_d, st_q;
    logic [CW-1:0] cnt_n;

    function automatic logic [USED_W-1:0] bump(input logic [USED_W-1:0] p);
        return (p == USED_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        rd_ok = rd_req & ~sclr & (~GUARD_UNF | ~st_q.empty);
        wr_ok = wr_req & ~sclr & (~GUARD_OVF | ~st_q.full | (FULL_RW & rd_ok));
        cnt_n = st_q.cnt + CW'(wr_ok) - CW'(rd_ok);
        st_d  = st_q;
        if (sclr) begin
            st_d = CLEARED;
        end else begin
            if (wr_ok) st_d.wp = bump(st_q.wp);
            if (rd_ok) st_d.rp = bump(st_q.rp);
            st_d.cnt   = cnt_n;
            st_d.full  = (cnt_n == DEPTH_C);
            st_d.empty = (cnt_n == '0);
            st_d.af    = (cnt_n >= AF_C);
            st_d.ae    = (cnt_n < AE_C);
        end
    end

    always_ff @(posedge clk or posedge aclr) begin
        if (aclr) st_q <= CLEARED;
        else      st_q <= st_d;
    end

    assign wr_ptr       = st_q.wp;
    assign rd_ptr       = st_q.rp;
    assign used_words   = st_q.cnt[USED_W-1:0];
    assign full         = st_q.full;
    assign empty        = st_q.empty;
    assign almost_full  = st_q.af;
    assign almost_empty = st_q.ae;

    a_r7_full_empty_exclusive: assert property (@(posedge clk) disable iff (aclr)
        !(full && empty));

    a_r9_sync_clear: assert property (@(posedge clk) disable iff (aclr)
        sclr |=> (empty && !full && st_q.cnt == '0 && almost_empty && !almost_full));

    a_r12_balanced_count: assert property (@(posedge clk) disable iff (aclr)
        (!full && !empty && wr_req && rd_req && !sclr) |=> $stable(st_q.cnt));

    a_r8_af_tracks_count: assert property (@(posedge clk) disable iff (aclr)
        almost_full == (st_q.cnt >= AF_C));

    generate
        if (GUARD_OVF) begin : g_ovf
            a_r4_no_overflow: assert property (@(posedge clk) disable iff (aclr)
                (full && wr_req && !rd_req && !sclr) |=> (full && $stable(st_q.cnt)));
            if (FULL_RW) begin : g_frw
                a_r6_stay_full: assert property (@(posedge clk) disable iff (aclr)
                    (full && wr_req && rd_req && !sclr) |=> full);
            end
        end
        if (GUARD_UNF) begin : g_unf
            a_r5_no_underflow: assert property (@(posedge clk) disable iff (aclr)
                (empty && rd_req && !wr_req && !sclr) |=> (empty && st_q.cnt == '0));
        end
    endgenerate
endmodule

// File: rtl/sfifo_rdport.sv
module sfifo_rdport
    import sfifo_pkg::*;
#(
    parameter int       DATA_W  = 8,
    parameter rd_mode_e RD_MODE = RD_NORMAL
) (
    input  logic              clk,
    input  logic              aclr,
    input  logic              sclr,
    input  logic              rd_ok,
    input  logic [DATA_W-1:0] head_word,
    output logic [DATA_W-1:0] rd_data
);
    generate
        if (RD_MODE == RD_NORMAL) begin : g_normal
            logic [DATA_W-1:0] out_d, out_q;
            always_comb begin
                out_d = out_q;
                if (rd_ok) out_d = head_word;
            end
            always_ff @(posedge clk) begin
                out_q <= out_d;
            end
            assign rd_data = out_q;
        end else begin : g_lookahead
            logic              hold_d, hold_q;
            logic [DATA_W-1:0] shadow_d, shadow_q;
            always_comb begin
                hold_d   = sclr;
                shadow_d = rd_data;
            end
            always_ff @(posedge clk or posedge aclr) begin
                if (aclr) hold_q <= 1'b0;
                else      hold_q <= hold_d;
            end
            always_ff @(posedge clk) begin
                shadow_q <= shadow_d;
            end
            assign rd_data = hold_q ? shadow_q : head_word;

            a_r11_hold_after_clear: assert property (@(posedge clk) disable iff (aclr)
                sclr |=> (rd_data == $past(rd_data)));
        end
    endgenerate
endmodule

// File: rtl/sfifo_la.sv
module sfifo_la
    import sfifo_pkg::*;
#(
    parameter int       DATA_W    = 8,
    parameter int       USED_W    = 3,
    parameter int       DEPTH     = 8,
    parameter rd_mode_e RD_MODE   = RD_NORMAL,
    parameter bit       GUARD_OVF = 1'b1,
    parameter bit       GUARD_UNF = 1'b1,
    parameter bit       FULL_RW   = 1'b0,
    parameter int       AF_LEVEL  = 6,
    parameter int       AE_LEVEL  = 2
) (
    input  logic              clk,
    input  logic              aclr,
    input  logic              sclr,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic [USED_W-1:0] used_words
);
    logic              wr_ok, rd_ok;
    logic [USED_W-1:0] wr_ptr, rd_ptr;
    logic [DATA_W-1:0] head_word;

    initial begin
        a_r1_depth_range: assert (DEPTH >= 4 && DEPTH <= (1 << USED_W))
            else $error("depth outside supported range");
    end

    sfifo_ctrl #(
        .DEPTH(DEPTH), .USED_W(USED_W), .GUARD_OVF(GUARD_OVF), .GUARD_UNF(GUARD_UNF),
        .FULL_RW(FULL_RW), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)
    ) u_ctrl (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr_req), .rd_req(rd_req),
        .wr_ok(wr_ok), .rd_ok(rd_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .used_words(used_words), .full(full), .empty(empty),
        .almost_full(almost_full), .almost_empty(almost_empty)
    );

    sfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(USED_W)) u_mem (
        .clk(clk), .we(wr_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(head_word)
    );

    sfifo_rdport #(.DATA_W(DATA_W), .RD_MODE(RD_MODE)) u_rd (
        .clk(clk), .aclr(aclr), .sclr(sclr), .rd_ok(rd_ok),
        .head_word(head_word), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_sfifo_la.sv
`timescale 1ns/1ps
module sim_sfifo_la;
    import sfifo_pkg::*;

    localparam int D = 8;

    logic clk = 1'b0;
    logic aclr, sclr, wr, rd;
    logic [7:0] din;
    logic [7:0] q0, q1;
    logic f0, e0, af0, ae0, f1, e1, af1, ae1;
    logic [2:0] uw0, uw1;

    always #2.5 clk = ~clk;

    sfifo_la #(.DATA_W(8), .USED_W(3), .DEPTH(D), .RD_MODE(RD_NORMAL), .FULL_RW(1'b0),
               .AF_LEVEL(6), .AE_LEVEL(2)) u0 (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr), .wr_data(din), .rd_req(rd),
        .rd_data(q0), .full(f0), .empty(e0), .almost_full(af0), .almost_empty(ae0),
        .used_words(uw0));

    sfifo_la #(.DATA_W(8), .USED_W(3), .DEPTH(D), .RD_MODE(RD_LOOKAHEAD), .FULL_RW(1'b1),
               .AF_LEVEL(6), .AE_LEVEL(2)) u1 (
        .clk(clk), .aclr(aclr), .sclr(sclr), .wr_req(wr), .wr_data(din), .rd_req(rd),
        .rd_data(q1), .full(f1), .empty(e1), .almost_full(af1), .almost_empty(ae1),
        .used_words(uw1));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int         cnt [2];
    int         hd  [2];
    logic [7:0] mem [2][D];
    bit         wrf [2];
    logic [7:0] expq0;
    bit         expq0_v;
    logic [7:0] hold1;
    bit         hold1_v;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            cnt[k] = 0;
            hd[k]  = 0;
        end
    endtask

    task automatic model_step();
        bit rok, wok;
        hold1_v = 1'b0;
        if (aclr) begin
            model_clear();
        end else if (sclr) begin
            if (cnt[1] > 0) begin
                hold1   = mem[1][hd[1]];
                hold1_v = 1'b1;
            end
            model_clear();
        end else begin
            for (int k = 0; k < 2; k++) begin
                rok = rd && cnt[k] > 0;
                wok = wr && (cnt[k] < D || (wrf[k] && rok));
                if (rok) begin
                    if (k == 0) begin
                        expq0   = mem[0][hd[0]];
                        expq0_v = 1'b1;
                    end
                    hd[k]  = (hd[k] + 1) % D;
                    cnt[k] = cnt[k] - 1;
                end
                if (wok) begin
                    mem[k][(hd[k] + cnt[k]) % D] = din;
                    cnt[k] = cnt[k] + 1;
                end
            end
        end
    endtask

    task automatic check_all();
        chk("R7 full u0", f0, cnt[0] == D);
        chk("R7 full u1", f1, cnt[1] == D);
        chk("R7 empty u0", e0, cnt[0] == 0);
        chk("R7 empty u1", e1, cnt[1] == 0);
        chk("R7 used_words u0", uw0, cnt[0] % D);
        chk("R7 used_words u1", uw1, cnt[1] % D);
        chk("R8 almost_full u0", af0, cnt[0] >= 6);
        chk("R8 almost_full u1", af1, cnt[1] >= 6);
        chk("R8 almost_empty u0", ae0, cnt[0] < 2);
        chk("R8 almost_empty u1", ae1, cnt[1] < 2);
        if (expq0_v) chk("R2 normal data", q0, expq0);
        if (hold1_v) chk("R11 lookahead hold", q1, hold1);
        else if (cnt[1] > 0) chk("R3 lookahead head", q1, mem[1][hd[1]]);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic drive(input bit w, input bit r, input logic [7:0] d, input bit s);
        wr = w; rd = r; din = d; sclr = s;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        wrf[0] = 1'b0; wrf[1] = 1'b1;
        expq0 = '0; expq0_v = 1'b0; hold1 = '0; hold1_v = 1'b0;
        aclr = 1'b1;
        drive(0, 0, 8'h00, 0);
        model_clear();
        #1;
        chk("R10 reset empty u0", e0, 1);
        chk("R10 reset empty u1", e1, 1);
        chk("R10 reset almost_empty", ae0, 1);
        cyc();
        aclr = 1'b0;
        cyc();

        // fill beyond depth: ninth write must be refused
        for (int i = 0; i < D + 1; i++) begin
            drive(1, 0, 8'(i + 1), 0);
            cyc();
        end
        drive(0, 0, 8'h00, 0);
        chk("R4 full after extra write u0", f0, 1);
        chk("R4 full after extra write u1", f1, 1);
        chk("R1 used_words wraps at depth", uw0, 0);

        // combined request while full
        drive(1, 1, 8'hA0, 0);
        cyc();
        drive(0, 0, 8'h00, 0);
        chk("R6 option on stays full", f1, 1);
        chk("R6 option off drops full", f0, 0);
        chk("R6 option off count", uw0, 7);

        // drain past empty
        drive(0, 1, 8'h00, 0);
        repeat (12) cyc();
        chk("R5 empty after overread u0", e0, 1);
        chk("R5 empty after overread u1", e1, 1);
        chk("R5 normal data held", q0, expq0);
        drive(0, 0, 8'h00, 0);

        // balanced request in the middle
        for (int i = 0; i < 3; i++) begin
            drive(1, 0, 8'(8'h30 + i), 0);
            cyc();
        end
        drive(1, 1, 8'h55, 0);
        cyc();
        drive(0, 0, 8'h00, 0);
        chk("R12 count unchanged u0", uw0, 3);
        chk("R12 count unchanged u1", uw1, 3);

        // random traffic with biased phases and rare clears
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < 100; i++) begin
                bit w, r, s;
                w = ($urandom_range(0, 9) < ((p % 2 == 0) ? 8 : 3));
                r = ($urandom_range(0, 9) < ((p % 2 == 0) ? 3 : 8));
                s = ($urandom_range(0, 79) == 0);
                drive(w, r, 8'($urandom), s);
                cyc();
            end
        end
        drive(0, 0, 8'h00, 0);
        cyc();

        // synchronous clear mid-stream with requests present
        for (int i = 0; i < 4; i++) begin
            drive(1, (i == 3), 8'(8'h70 + i), 0);
            cyc();
        end
        drive(1, 1, 8'hEE, 1);
        cyc();
        drive(0, 0, 8'h00, 0);
        chk("R9 empty after sclr u0", e0, 1);
        chk("R9 empty after sclr u1", e1, 1);
        chk("R9 count after sclr", uw1, 0);
        chk("R9 almost_full low", af0, 0);
        chk("R9 normal data kept", q0, expq0);
        chk("R11 lookahead held word", q1, hold1);
        cyc();

        // asynchronous clear mid-stream
        for (int i = 0; i < 5; i++) begin
            drive(1, (i == 4), 8'(8'h90 + i), 0);
            cyc();
        end
        drive(1, 0, 8'hBB, 0);
        aclr = 1'b1;
        #1;
        model_clear();
        chk("R10 immediate empty u0", e0, 1);
        chk("R10 immediate empty u1", e1, 1);
        chk("R10 immediate count", uw0, 0);
        chk("R10 normal data kept", q0, expq0);
        cyc();
        aclr = 1'b0;
        drive(0, 0, 8'h00, 0);
        cyc();
        chk("R10 still empty after release", e0, 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end
endmodule